// File: doc/BRIEF.md
# Mode-configurable sum-of-products output macrocell

This block is one output cell of a sum-of-products programmable logic device. It takes the product terms that the AND array produces for the cell and ORs them into a sum. It applies a programmable polarity to that sum. It then routes the result through either a clocked register or a direct combinatorial path to a tristate pin model. It also returns a feedback bit to the array.

Three configuration pins choose how the cell behaves:

- A two-bit global mode: registered, complex or simple.
- A per-cell flag that makes the cell a registered output.
- A per-cell flag that makes the cell a dedicated input.

The mode decides how many product terms reach the sum and where the output enable comes from. A compile-time position parameter marks the outermost and centre cells of the device, and the mode uses it when it selects the feedback path. A synchronous preload port forces the register to any value, so a test can start from a known state.

All pins are plain control and data levels that are sampled or resolved every cycle. The cell has no streaming transfer, so there is no valid/ready handshake and back-pressure does not apply.

Top module: `sop_macrocell`

## Requirements
- R1: While rst_n is low, the register is held at 0. In registered mode, a registered cell then drives 0 when the global enable is high and feeds back 1.
- R2: On each rising clk edge without preload, in every mode, the register captures (OR of all NUM_PT product terms) XOR polarity_i. In registered mode with cell_reg_i=1 and cell_input_i=0, the pin drives the register value, and pin_oe_o equals oe_pin_i.
- R3: For a registered cell in registered mode (mode_i=2'b00), fb_o is the inverse of the register, whatever the pin carries.
- R4: In registered mode with cell_reg_i=0 and cell_input_i=0, the cell drives (OR of product terms 0..NUM_PT-2) XOR polarity_i. Its enable is product term NUM_PT-1, and fb_o is the resolved pin.
- R5: When cell_input_i=1 is honoured, pin_oe_o is 0 and fb_o is the resolved pin. The flag is honoured in every mode except for an outermost cell in complex mode and a centre cell in simple mode. It takes priority over cell_reg_i.
- R6: In complex mode (mode_i=2'b01), every driving cell uses the seven-term sum with product term NUM_PT-1 as its enable. The outermost cells (CELL_IDX 0 and NUM_CELLS-1) give fb_o=0 and ignore cell_input_i.
- R7: In complex mode, the inner cells feed the resolved pin back on fb_o.
- R8: In simple mode (mode_i=2'b10), a driving cell is always enabled and drives (OR of all terms) XOR polarity_i. The centre cells (CELL_IDX NUM_CELLS/2-1 and NUM_CELLS/2) ignore cell_input_i and give fb_o=0, while the other cells feed the pin back.
- R9: When preload_en_i is high at a rising clk edge, the register loads preload_val_i in any mode. The product terms have no effect at that edge.
- R10: polarity_i=1 inverts the sum before it reaches the register or the output path.
- R11: When pin_oe_o=1, pin_o carries the cell's value. When pin_oe_o=0, pin_o carries pin_ext_i if pin_ext_drive_i=1, and otherwise 1 through the pull-up.
- R12: mode_i=2'b11 behaves exactly as simple mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset of the register |
| mode_i | input | 2 | Global mode: 00 registered, 01 complex, 10/11 simple |
| cell_reg_i | input | 1 | Registered-output option, used in registered mode |
| cell_input_i | input | 1 | Dedicated-input option |
| polarity_i | input | 1 | 1 inverts the sum term |
| pt_i | input | NUM_PT | Product terms from the AND array; the top bit doubles as the enable term |
| oe_pin_i | input | 1 | Global output enable, active high |
| preload_en_i | input | 1 | Load the register from preload_val_i at the next edge |
| preload_val_i | input | 1 | Value forced into the register |
| pin_ext_drive_i | input | 1 | An external source drives the pin |
| pin_ext_i | input | 1 | Value of the external source |
| pin_o | output | 1 | Resolved pin level |
| pin_oe_o | output | 1 | Cell drives the pin |
| fb_o | output | 1 | Feedback into the AND array |

## Verification
The bench builds three copies with NUM_PT=8 and NUM_CELLS=8, placed at CELL_IDX 0, 1 and 3. These are an outermost, an inner and a centre cell, and all three receive the same stimulus. Only that set of positions makes the complex-mode loss of feedback, the simple-mode forced output and the ordinary pin-feedback path all visible in the same cycle. As a result, a fault in the position decode shows up as a disagreement between instances.

// File: rtl/sop_mc_pkg.sv
package sop_mc_pkg;
  typedef enum logic [1:0] {
    MODE_REG      = 2'b00,
    MODE_CPLX     = 2'b01,
    MODE_SIMP     = 2'b10,
    MODE_SIMP_ALT = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    OE_OFF    = 2'd0,
    OE_GLOBAL = 2'd1,
    OE_TERM   = 2'd2,
    OE_ALWAYS = 2'd3
  } oe_src_e;

  typedef enum logic [1:0] {
    FB_PIN  = 2'd0,
    FB_QBAR = 2'd1,
    FB_NONE = 2'd2
  } fb_src_e;

  typedef struct packed {
    logic    use_reg;
    logic    full_sum;
    oe_src_e oe_src;
    fb_src_e fb_src;
  } cell_ctl_t;
endpackage

// File: rtl/sop_mc_route.sv
module sop_mc_route
  import sop_mc_pkg::*;
#(
  parameter bit IS_OUTER  = 1'b0,
  parameter bit IS_CENTRE = 1'b0
) (
  input  mode_e     mode,
  input  logic      cell_reg,
  input  logic      cell_input,
  output cell_ctl_t ctl
);
  logic honour_input;

  always_comb begin
    honour_input = cell_input;
    if (mode == MODE_CPLX && IS_OUTER) honour_input = 1'b0;
    if ((mode == MODE_SIMP || mode == MODE_SIMP_ALT) && IS_CENTRE) honour_input = 1'b0;

    ctl = '{use_reg: 1'b0, full_sum: 1'b0, oe_src: OE_OFF, fb_src: FB_PIN};
    case (mode)
      MODE_REG: begin
        if (!honour_input) begin
          if (cell_reg) begin
            ctl.use_reg  = 1'b1;
            ctl.full_sum = 1'b1;
            ctl.oe_src   = OE_GLOBAL;
            ctl.fb_src   = FB_QBAR;
          end else begin
            ctl.oe_src = OE_TERM;
          end
        end
      end
      MODE_CPLX: begin
        if (!honour_input) ctl.oe_src = OE_TERM;
        if (IS_OUTER) ctl.fb_src = FB_NONE;
      end
      default: begin
        if (!honour_input) begin
          ctl.full_sum = 1'b1;
          ctl.oe_src   = OE_ALWAYS;
        end
        if (IS_CENTRE) ctl.fb_src = FB_NONE;
      end
    endcase
  end
endmodule

// File: rtl/sop_mc_sum.sv
module sop_mc_sum #(
  parameter int NUM_PT = 8
) (
  input  logic [NUM_PT-1:0] pt,
  input  logic              polarity,
  output logic              sum_all_x,
  output logic              sum_part_x,
  output logic              oe_term
);
  logic [NUM_PT-1:0] prefix;

  assign prefix[0] = pt[0];
  for (genvar g = 1; g < NUM_PT; g++) begin : g_or_chain
    assign prefix[g] = prefix[g-1] | pt[g];
  end

  assign sum_all_x  = prefix[NUM_PT-1] ^ polarity;
  assign sum_part_x = prefix[NUM_PT-2] ^ polarity;
  assign oe_term    = pt[NUM_PT-1];
endmodule

// File: rtl/sop_mc_reg.sv
module sop_mc_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  input  logic preload_en,
  input  logic preload_val,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= 1'b0;
    else if (preload_en) q <= preload_val;
    else                 q <= d;
  end
endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell
  import sop_mc_pkg::*;
#(
  parameter int NUM_PT    = 8,
  parameter int NUM_CELLS = 8,
  parameter int CELL_IDX  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              cell_reg_i,
  input  logic              cell_input_i,
  input  logic              polarity_i,
  input  logic [NUM_PT-1:0] pt_i,
  input  logic              oe_pin_i,
  input  logic              preload_en_i,
  input  logic              preload_val_i,
  input  logic              pin_ext_drive_i,
  input  logic              pin_ext_i,
  output logic              pin_o,
  output logic              pin_oe_o,
  output logic              fb_o
);
  localparam bit IS_OUTER  = (CELL_IDX == 0) || (CELL_IDX == NUM_CELLS - 1);
  localparam bit IS_CENTRE = (CELL_IDX == NUM_CELLS / 2 - 1) || (CELL_IDX == NUM_CELLS / 2);

  cell_ctl_t ctl;
  logic      sum_all_x, sum_part_x, oe_term;
  logic      q_w, drive_val;

  sop_mc_route #(.IS_OUTER(IS_OUTER), .IS_CENTRE(IS_CENTRE)) route_i (
    .mode       (mode_e'(mode_i)),
    .cell_reg   (cell_reg_i),
    .cell_input (cell_input_i),
    .ctl        (ctl)
  );

  sop_mc_sum #(.NUM_PT(NUM_PT)) sum_i (
    .pt         (pt_i),
    .polarity   (polarity_i),
    .sum_all_x  (sum_all_x),
    .sum_part_x (sum_part_x),
    .oe_term    (oe_term)
  );

  sop_mc_reg reg_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .d           (sum_all_x),
    .preload_en  (preload_en_i),
    .preload_val (preload_val_i),
    .q           (q_w)
  );

  always_comb begin
    if (ctl.use_reg)       drive_val = q_w;
    else if (ctl.full_sum) drive_val = sum_all_x;
    else                   drive_val = sum_part_x;

    case (ctl.oe_src)
      OE_GLOBAL: pin_oe_o = oe_pin_i;
      OE_TERM:   pin_oe_o = oe_term;
      OE_ALWAYS: pin_oe_o = 1'b1;
      default:   pin_oe_o = 1'b0;
    endcase

    if (pin_oe_o)             pin_o = drive_val;
    else if (pin_ext_drive_i) pin_o = pin_ext_i;
    else                      pin_o = 1'b1;

    case (ctl.fb_src)
      FB_QBAR: fb_o = ~q_w;
      FB_NONE: fb_o = 1'b0;
      default: fb_o = pin_o;
    endcase
  end
endmodule

// File: rtl/sop_macrocell_chk.sv
module sop_macrocell_chk #(
  parameter int NUM_PT    = 8,
  parameter int NUM_CELLS = 8,
  parameter int CELL_IDX  = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_i,
  input logic              cell_reg_i,
  input logic              cell_input_i,
  input logic              polarity_i,
  input logic [NUM_PT-1:0] pt_i,
  input logic              oe_pin_i,
  input logic              preload_en_i,
  input logic              preload_val_i,
  input logic              pin_ext_drive_i,
  input logic              pin_ext_i,
  input logic              pin_o,
  input logic              pin_oe_o,
  input logic              fb_o,
  input logic              q_w
);
  localparam bit OUTER  = (CELL_IDX == 0) || (CELL_IDX == NUM_CELLS - 1);
  localparam bit CENTRE = (CELL_IDX == NUM_CELLS / 2 - 1) || (CELL_IDX == NUM_CELLS / 2);

  logic reg_cell;
  assign reg_cell = (mode_i == 2'b00) && cell_reg_i && !cell_input_i;

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !preload_en_i |=> q_w == ($past(|pt_i) ^ $past(polarity_i)));

  a_r2_global_oe: assert property (@(posedge clk) disable iff (!rst_n)
    reg_cell |-> (pin_oe_o == oe_pin_i));

  a_r9_preload: assert property (@(posedge clk) disable iff (!rst_n)
    preload_en_i |=> q_w == $past(preload_val_i));

  a_r3_qbar_fb: assert property (@(posedge clk) disable iff (!rst_n)
    reg_cell |-> (fb_o == !q_w));

  a_r5_input_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_input_i && !(mode_i == 2'b01 && OUTER) && !(mode_i[1] && CENTRE)) |-> !pin_oe_o);

  a_r6_term_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01 && (!cell_input_i || OUTER)) |-> (pin_oe_o == pt_i[NUM_PT-1]));

  a_r6_outer_nofb: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01 && OUTER) |-> !fb_o);

  a_r8_simple_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i[1] && (!cell_input_i || CENTRE)) |-> (pin_oe_o && (pin_o == ((|pt_i) ^ polarity_i))));

  a_r11_pullup: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_oe_o && !pin_ext_drive_i) |-> pin_o);

  a_r11_external: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_oe_o && pin_ext_drive_i) |-> (pin_o == pin_ext_i));
endmodule

bind sop_macrocell sop_macrocell_chk #(
  .NUM_PT(NUM_PT), .NUM_CELLS(NUM_CELLS), .CELL_IDX(CELL_IDX)
) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cell_reg_i(cell_reg_i),
  .cell_input_i(cell_input_i), .polarity_i(polarity_i), .pt_i(pt_i),
  .oe_pin_i(oe_pin_i), .preload_en_i(preload_en_i), .preload_val_i(preload_val_i),
  .pin_ext_drive_i(pin_ext_drive_i), .pin_ext_i(pin_ext_i), .pin_o(pin_o),
  .pin_oe_o(pin_oe_o), .fb_o(fb_o), .q_w(q_w)
);

// File: tb/sop_macrocell_tb_top.sv
`timescale 1ns/1ps
module sop_macrocell_tb_top;
  localparam int NPT = 8;
  localparam int NC  = 8;
  localparam int IDX0 = 0;
  localparam int IDX1 = 1;
  localparam int IDX2 = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic creg = 1'b1, cin = 1'b0, pol = 1'b0, oeg = 1'b1;
  logic [NPT-1:0] pt = '0;
  logic pe = 1'b0, pv = 1'b0, xd = 1'b0, xv = 1'b0;
  logic pin_w [3];
  logic oe_w  [3];
  logic fb_w  [3];

  int n_cmp = 0, n_bad = 0;
  bit mq = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sop_macrocell #(.NUM_PT(NPT), .NUM_CELLS(NC), .CELL_IDX(IDX0)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .cell_reg_i(creg), .cell_input_i(cin),
    .polarity_i(pol), .pt_i(pt), .oe_pin_i(oeg), .preload_en_i(pe), .preload_val_i(pv),
    .pin_ext_drive_i(xd), .pin_ext_i(xv), .pin_o(pin_w[0]), .pin_oe_o(oe_w[0]), .fb_o(fb_w[0]));
  sop_macrocell #(.NUM_PT(NPT), .NUM_CELLS(NC), .CELL_IDX(IDX1)) dut_inner (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .cell_reg_i(creg), .cell_input_i(cin),
    .polarity_i(pol), .pt_i(pt), .oe_pin_i(oeg), .preload_en_i(pe), .preload_val_i(pv),
    .pin_ext_drive_i(xd), .pin_ext_i(xv), .pin_o(pin_w[1]), .pin_oe_o(oe_w[1]), .fb_o(fb_w[1]));
  sop_macrocell #(.NUM_PT(NPT), .NUM_CELLS(NC), .CELL_IDX(IDX2)) dut_centre (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .cell_reg_i(creg), .cell_input_i(cin),
    .polarity_i(pol), .pt_i(pt), .oe_pin_i(oeg), .preload_en_i(pe), .preload_val_i(pv),
    .pin_ext_drive_i(xd), .pin_ext_i(xv), .pin_o(pin_w[2]), .pin_oe_o(oe_w[2]), .fb_o(fb_w[2]));

  // Expected {pin, oe, fb} for a cell at position idx, from the requirements.
  function automatic logic [2:0] expect_cell(int idx);
    bit outer  = (idx == 0) || (idx == NC - 1);
    bit centre = (idx == NC / 2 - 1) || (idx == NC / 2);
    int md = (mode == 2'b11) ? 2 : int'(mode);            // R12
    bit all8 = (pt != '0) ^ pol;                           // R10
    bit low7 = ((pt & {1'b0, {(NPT-1){1'b1}}}) != '0) ^ pol;
    bit as_input = cin;
    bit val = 1'b0, en = 1'b0, p, f;
    int fsel = 0;                                          // 0 pin, 1 inverted reg, 2 zero
    if (md == 1 && outer)  as_input = 1'b0;
    if (md == 2 && centre) as_input = 1'b0;
    if (md == 0) begin
      if (!as_input && creg) begin val = mq; en = oeg; fsel = 1; end
      else if (!as_input) begin val = low7; en = pt[NPT-1]; end
    end else if (md == 1) begin
      if (!as_input) begin val = low7; en = pt[NPT-1]; end
      if (outer) fsel = 2;
    end else begin
      if (!as_input) begin val = all8; en = 1'b1; end
      if (centre) fsel = 2;
    end
    p = en ? val : (xd ? xv : 1'b1);                       // R11
    f = (fsel == 1) ? !mq : ((fsel == 2) ? 1'b0 : p);
    return {p, en, f};
  endfunction

  task automatic cmp1(string tag, string what, int idx, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cell%0d %s actual=%b expected=%b at %0t", tag, idx, what, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    int pos [3] = '{IDX0, IDX1, IDX2};
    for (int k = 0; k < 3; k++) begin
      logic [2:0] e = expect_cell(pos[k]);
      cmp1(tag, "pin", pos[k], pin_w[k], e[2]);
      cmp1(tag, "oe",  pos[k], oe_w[k],  e[1]);
      cmp1(tag, "fb",  pos[k], fb_w[k],  e[0]);
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    if (!rst_n)  mq = 1'b0;
    else if (pe) mq = pv;
    else         mq = (pt != '0) ^ pol;
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state, registered cell with global enable on and all terms set
    mode = 2'b00; creg = 1'b1; oeg = 1'b1; pt = '1;
    @(negedge clk); check_all("R1");
    tick("R1");
    tick("R1");
    rst_n = 1'b1;

    // R2 and R10: capture of the full sum, both polarities, global enable toggled
    foreach (pt[b]) begin
      pt = NPT'(1) << b; pol = 1'b0; tick("R2");
      pt = '0;           tick("R2");
      pol = 1'b1;        tick("R10");
      oeg = ~oeg;        tick("R2");
    end

    // R9: preload wins over the array
    pol = 1'b0; pt = '1; pe = 1'b1; pv = 1'b0; tick("R9");
    pt = '0; pv = 1'b1; tick("R9");
    pe = 1'b0; tick("R9");

    // R3: inverted register feedback while an external source drives the pin
    oeg = 1'b0; xd = 1'b1;
    pt = 8'h10; xv = 1'b1; tick("R3");
    xv = 1'b0; tick("R3");
    pt = '0; tick("R3");

    // R4: combinatorial cell in registered mode
    creg = 1'b0; oeg = 1'b1; xd = 1'b0;
    pt = 8'h80; tick("R4");
    pt = 8'h81; tick("R4");
    pt = 8'h01; tick("R4");
    pol = 1'b1; pt = 8'h80; tick("R4");
    pol = 1'b0;

    // R5: dedicated input overrides the registered option
    cin = 1'b1; creg = 1'b1; xd = 1'b1; xv = 1'b0; tick("R5");
    xv = 1'b1; tick("R5");
    xd = 1'b0; tick("R5");

    // R6 and R7: complex mode, input flag on, then off
    mode = 2'b01; pt = 8'hC2; xd = 1'b1; xv = 1'b0; tick("R6");
    xv = 1'b1; tick("R7");
    cin = 1'b0; pt = 8'h02; xv = 1'b0; tick("R7");
    pt = 8'h82; tick("R6");
    pt = 8'h80; pol = 1'b1; tick("R6");
    pol = 1'b0;

    // R8: simple mode, input flag on then off
    mode = 2'b10; cin = 1'b1; pt = 8'h80; xv = 1'b0; tick("R8");
    xd = 1'b0; tick("R8");
    cin = 1'b0; tick("R8");
    pt = '0; tick("R8");

    // R11: pull-up against external drive with the enable off
    mode = 2'b00; creg = 1'b0; pt = 8'h01; xd = 1'b0; tick("R11");
    xd = 1'b1; xv = 1'b0; tick("R11");
    xv = 1'b1; tick("R11");

    // R12: the spare mode code acts as simple mode
    mode = 2'b11; cin = 1'b1; xd = 1'b1; xv = 1'b0; pt = 8'h40; tick("R12");
    cin = 1'b0; pt = '0; tick("R12");

    // Mixed stimulus across all modes
    for (int i = 0; i < 600; i++) begin
      mode = 2'($urandom); creg = 1'($urandom); cin = 1'($urandom);
      pol = 1'($urandom); pt = NPT'($urandom); oeg = 1'($urandom);
      pe = (($urandom % 8) == 0); pv = 1'($urandom);
      xd = 1'($urandom); xv = 1'($urandom);
      tick("random R2 R4 R5 R6 R7 R8 R9");
    end

    finish_run();
  end
endmodule